// File: doc/BRIEF.md
# Four-Channel DMA Handshake Controller

This block is the device-side controller of a 32-bit parallel streaming bus. A host asks for transfers by pulling one of four active-low request lines low. Channels 0 and 1 carry receive traffic, so the device drives the bus toward the host. Channels 2 and 3 carry transmit traffic, so the host drives the bus and the device samples it. Two enable inputs, one for each direction, decide whether requests of that direction may be served. Either enable may drop between blocks and return later.

When it is idle, the controller chooses one eligible request. It answers with a one-cycle, active-high acknowledge on that channel and then moves exactly `BLOCK_WORDS` words, one per clock, starting the cycle after the acknowledge. During a receive block it pops words from a receive FIFO port and drives them onto the bus with its output enable high. During a transmit block it passes the sampled bus word to a transmit FIFO port with a valid strobe. The host releases its request two cycles after it sees the acknowledge. The controller is in the middle of the block during that window, so the request cannot start a second block.

The state machine has four states. `ST_IDLE` moves to `ST_GRANT` when a request is eligible ("pick"). `ST_GRANT` moves to `ST_RX_BURST` or `ST_TX_BURST` according to the direction of the chosen channel ("launch"). Each burst state returns to `ST_IDLE` after its last word ("finish"). The system reset, which is high at startup, forces `ST_IDLE` from any state.

Top module: `dmah_ctrl`

## Requirements
- R1: While `sys_rst` is high, `ack` is 0, `bus_oe` is 0 and `underrun` is cleared. After reset the arbitration history is restored: receive before transmit, and channel 0 before 1, channel 2 before 3.
- R2: `ack` is one-hot with bit i for channel i. It is high for exactly one cycle and appears in the cycle after an edge at which the idle controller sampled an eligible request low.
- R3: Channels 0 and 1 are receive channels, during which the device drives the bus. Channels 2 and 3 are transmit channels, during which the device samples `bus_in`.
- R4: Every block lasts exactly `BLOCK_WORDS` (512 by default) consecutive cycles, beginning in the cycle after the acknowledge.
- R5: A receive channel is granted only if `rx_enable` was high at the edge that chose it. Pending receive requests are held off while it is low.
- R6: A transmit channel is granted only if `tx_enable` was high at the edge that chose it. Pending transmit requests are held off while it is low.
- R7: Each block gets exactly one acknowledge. A request still held low in the two cycles after the acknowledge does not produce a second one. The next acknowledge comes no earlier than two cycles after the last word.
- R8: When requests of both directions are eligible, the direction alternates with the direction served last.
- R9: When both channels of the chosen direction are pending, the channel alternates with the one of that direction served last.
- R10: `bus_oe` is high only during receive-block words. During a transmit block, `txf_valid` is high on every word and `txf_data` equals `bus_in` of that cycle.
- R11: During a receive block, `rxf_ready` is high on every word and FIFO words appear on `bus_out` in pop order. A word for which `rxf_valid` is low is driven as zero and sets `underrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| sys_rst | input | 1 | Synchronous system reset, active high |
| req_n | input | 4 | Per-channel request, active low |
| rx_enable | input | 1 | Allows receive channels 0 and 1 |
| tx_enable | input | 1 | Allows transmit channels 2 and 3 |
| ack | output | 4 | Per-channel acknowledge, one-cycle pulse |
| bus_in | input | 32 | Bus value sampled from the pins |
| bus_out | output | 32 | Bus value driven during receive blocks |
| bus_oe | output | 1 | Output enable for bus_out |
| rxf_data | input | 32 | Receive FIFO head word |
| rxf_valid | input | 1 | Receive FIFO has a word |
| rxf_ready | output | 1 | Receive FIFO pop |
| txf_data | output | 32 | Word for the transmit FIFO |
| txf_valid | output | 1 | Transmit FIFO push |
| underrun | output | 1 | Sticky receive underrun flag |

## Verification
A stuck or mis-decoded state shows at the ports within one cycle. Examples are an acknowledge wider than one cycle, two acks in one block, or `bus_oe` and `txf_valid` high together. A wrong beat count shows when the block ends, as a run of `bus_oe` or `txf_valid` that is one word short or long of `BLOCK_WORDS`. Corrupted arbitration history shows only at the next grant where the choice is contested, as the wrong channel bit in `ack`. For that reason the bench holds competing requests through several consecutive blocks.

// File: rtl/dmah_pkg.sv
package dmah_pkg;
    localparam int NUM_CH  = 4;
    localparam int CH_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GRANT    = 2'd1,
        ST_RX_BURST = 2'd2,
        ST_TX_BURST = 2'd3
    } dmah_state_e;
endpackage

// File: rtl/dmah_pick.sv
// Round-robin choice among eligible channels: direction first, then channel.
module dmah_pick
    import dmah_pkg::*;
(
    input  logic [NUM_CH-1:0] pend,
    input  logic              last_dir,   // 0 = receive served last, 1 = transmit
    input  logic              last_rx,    // channel bit last served in receive pair
    input  logic              last_tx,    // channel bit last served in transmit pair
    output logic              any,
    output logic [CH_W-1:0]   ch
);
    localparam int NUM_DIR = NUM_CH / 2;

    logic [NUM_DIR-1:0] dir_any;
    logic [NUM_DIR-1:0] dir_sel;
    logic [NUM_DIR-1:0] last_in;
    logic               dir;

    assign last_in = {last_tx, last_rx};

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        logic [1:0] pair;
        assign pair       = pend[2*g +: 2];
        assign dir_any[g] = |pair;
        // both pending: alternate; otherwise take the only one pending
        assign dir_sel[g] = (pair == 2'b11) ? ~last_in[g] : pair[1];
    end

    always_comb begin
        any = |dir_any;
        if (dir_any[0] && dir_any[1]) begin
            dir = ~last_dir;
        end else begin
            dir = dir_any[1];
        end
        ch = {dir, dir_sel[dir]};
    end
endmodule

// File: rtl/dmah_beat_ctr.sv
// Counts words of a block; flags the last one.
module dmah_beat_ctr #(
    parameter int BLOCK_WORDS = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(BLOCK_WORDS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_IDX);
endmodule

// File: rtl/dmah_ctrl.sv
// Device-side controller: grants one of four DMA requests and moves one block.
module dmah_ctrl
    import dmah_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BLOCK_WORDS = 512
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic [3:0]        req_n,
    input  logic              rx_enable,
    input  logic              tx_enable,
    output logic [3:0]        ack,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] rxf_data,
    input  logic              rxf_valid,
    output logic              rxf_ready,
    output logic [DATA_W-1:0] txf_data,
    output logic              txf_valid,
    output logic              underrun
);
    dmah_state_e       state, state_d;
    logic [CH_W-1:0]   ch_q;
    logic              last_dir, last_rx, last_tx;
    logic [NUM_CH-1:0] pend;
    logic              pick_any;
    logic [CH_W-1:0]   pick_ch;
    logic              in_burst;
    logic              beat_last;

    // requests are active low; each direction is gated by its enable
    assign pend = ~req_n & {{2{tx_enable}}, {2{rx_enable}}};

    dmah_pick u_pick (
        .pend     (pend),
        .last_dir (last_dir),
        .last_rx  (last_rx),
        .last_tx  (last_tx),
        .any      (pick_any),
        .ch       (pick_ch)
    );

    assign in_burst = (state == ST_RX_BURST) || (state == ST_TX_BURST);

    dmah_beat_ctr #(.BLOCK_WORDS(BLOCK_WORDS)) u_beat (
        .clk  (clk),
        .rst  (sys_rst),
        .run  (in_burst),
        .last (beat_last)
    );

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:     if (pick_any) state_d = ST_GRANT;
            ST_GRANT:    state_d = ch_q[1] ? ST_TX_BURST : ST_RX_BURST;
            ST_RX_BURST: if (beat_last) state_d = ST_IDLE;
            ST_TX_BURST: if (beat_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and arbitration history
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            state    <= ST_IDLE;
            ch_q     <= '0;
            last_dir <= 1'b1;
            last_rx  <= 1'b1;
            last_tx  <= 1'b1;
            underrun <= 1'b0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && pick_any) begin
                ch_q     <= pick_ch;
                last_dir <= pick_ch[1];
                if (pick_ch[1]) begin
                    last_tx <= pick_ch[0];
                end else begin
                    last_rx <= pick_ch[0];
                end
            end
            if (state == ST_RX_BURST && !rxf_valid) begin
                underrun <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ack       = '0;
        bus_oe    = 1'b0;
        bus_out   = '0;
        rxf_ready = 1'b0;
        txf_valid = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_GRANT:    ack[ch_q] = 1'b1;
            ST_RX_BURST: begin
                bus_oe    = 1'b1;
                rxf_ready = 1'b1;
                bus_out   = rxf_valid ? rxf_data : '0;
            end
            ST_TX_BURST: txf_valid = 1'b1;
            default:     ;
        endcase
    end

    assign txf_data = bus_in;
endmodule

// File: rtl/dmah_ctrl_chk.sv
module dmah_ctrl_chk #(
    parameter int BLOCK_WORDS = 512
) (
    input logic       clk,
    input logic       sys_rst,
    input logic       rx_enable,
    input logic       tx_enable,
    input logic [3:0] ack,
    input logic       bus_oe,
    input logic       txf_valid,
    input logic       underrun
);
    localparam int RW = $clog2(BLOCK_WORDS + 1) + 1;

    logic          rst_seen = 1'b0;
    logic [RW-1:0] oe_run;

    always_ff @(posedge clk) begin
        if (sys_rst) rst_seen <= 1'b1;
        if (sys_rst || !bus_oe) begin
            oe_run <= '0;
        end else begin
            oe_run <= oe_run + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_seen)
        sys_rst |=> (ack == 4'b0 && !bus_oe && !underrun));

    assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (sys_rst)
        $onehot0(ack));

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (sys_rst)
        (ack != 4'b0) |=> (ack == 4'b0));

    assert_burst_len_R4: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(bus_oe) |-> (oe_run == RW'(BLOCK_WORDS)));

    assert_burst_max_R4: assert property (@(posedge clk) disable iff (sys_rst)
        oe_run <= RW'(BLOCK_WORDS));

    assert_rx_gate_R5: assert property (@(posedge clk) disable iff (sys_rst)
        (ack[1:0] != 2'b0) |-> $past(rx_enable));

    assert_tx_gate_R6: assert property (@(posedge clk) disable iff (sys_rst)
        (ack[3:2] != 2'b0) |-> $past(tx_enable));

    assert_no_regrant_R7: assert property (@(posedge clk) disable iff (sys_rst)
        (ack != 4'b0) |=> (ack == 4'b0) ##1 (ack == 4'b0));

    assert_one_dir_R10: assert property (@(posedge clk) disable iff (sys_rst)
        !(bus_oe && txf_valid));

    assert_quiet_on_ack_R10: assert property (@(posedge clk) disable iff (sys_rst)
        (ack != 4'b0) |-> (!bus_oe && !txf_valid));

    assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (sys_rst)
        underrun |=> underrun);
endmodule

bind dmah_ctrl dmah_ctrl_chk #(.BLOCK_WORDS(BLOCK_WORDS)) u_chk (
    .clk       (clk),
    .sys_rst   (sys_rst),
    .rx_enable (rx_enable),
    .tx_enable (tx_enable),
    .ack       (ack),
    .bus_oe    (bus_oe),
    .txf_valid (txf_valid),
    .underrun  (underrun)
);

// File: tb/tb_dmah_ctrl.sv
`timescale 1ns/1ps
module tb_dmah_ctrl;
    localparam int BW = 512;

    logic        clk = 1'b0;
    logic        sys_rst = 1'b1;
    logic [3:0]  req_n = 4'hF;
    logic        rx_enable = 1'b0;
    logic        tx_enable = 1'b0;
    logic [3:0]  ack;
    logic [31:0] bus_in = '0;
    logic [31:0] bus_out;
    logic        bus_oe;
    logic [31:0] rxf_data;
    logic        rxf_valid = 1'b1;
    logic        rxf_ready;
    logic [31:0] txf_data;
    logic        txf_valid;
    logic        underrun;

    int checks = 0;
    int failures = 0;
    int pop_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // receive FIFO model: counting pattern, advances on each pop
    assign rxf_data = 32'hA500_0000 + 32'(pop_cnt);
    always @(posedge clk) if (rxf_ready && rxf_valid) pop_cnt <= pop_cnt + 1;

    dmah_ctrl #(.DATA_W(32), .BLOCK_WORDS(BW)) dut (
        .clk(clk), .sys_rst(sys_rst), .req_n(req_n),
        .rx_enable(rx_enable), .tx_enable(tx_enable), .ack(ack),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rxf_data(rxf_data), .rxf_valid(rxf_valid), .rxf_ready(rxf_ready),
        .txf_data(txf_data), .txf_valid(txf_valid), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Wait for a grant, check channel, then run one block and check every word.
    task automatic do_block(input int exp_ch, input bit drop_all, input bit starve, input string tag);
        int waited = 0;
        int start;
        int lp = 0;
        int bad_oe = 0, bad_data = 0, bad_ack = 0, bad_tx = 0, bad_rdy = 0;
        logic [31:0] first_act = '0, first_exp = '0;
        bit is_rx = (exp_ch < 2);
        while (ack == 4'b0 && waited < 20) begin
            @(negedge clk);
            #1;
            waited++;
        end
        check(ack == 4'(1 << exp_ch), {tag, " R2 grant channel"}, {28'b0, ack}, 32'(1 << exp_ch));
        start = pop_cnt;
        for (int k = 0; k < BW; k++) begin
            @(negedge clk);
            if (k == 1 && drop_all) req_n = 4'hF;
            rxf_valid = !(starve && k >= 100 && k < 110);
            bus_in = 32'h5A00_0000 + 32'(k);
            #1;
            if (ack != 4'b0) bad_ack++;
            if (is_rx) begin
                logic [31:0] exp_w;
                exp_w = rxf_valid ? 32'hA500_0000 + 32'(start + lp) : 32'h0;
                if (rxf_valid) lp++;
                if (!bus_oe || txf_valid) bad_oe++;
                if (!rxf_ready) bad_rdy++;
                if (bus_out !== exp_w) begin
                    if (bad_data == 0) begin first_act = bus_out; first_exp = exp_w; end
                    bad_data++;
                end
            end else begin
                if (bus_oe || rxf_ready) bad_oe++;
                if (!txf_valid || txf_data !== bus_in) begin
                    if (bad_tx == 0) begin first_act = txf_data; first_exp = bus_in; end
                    bad_tx++;
                end
            end
        end
        rxf_valid = 1'b1;
        check(bad_ack == 0, {tag, " R7 no second ack in block"}, 32'(bad_ack), 0);
        if (is_rx) begin
            check(bad_oe == 0, {tag, " R3 R10 bus driven every rx word"}, 32'(bad_oe), 0);
            check(bad_rdy == 0, {tag, " R11 pop every rx word"}, 32'(bad_rdy), 0);
            check(bad_data == 0, {tag, " R11 rx word order"}, first_act, first_exp);
        end else begin
            check(bad_oe == 0, {tag, " R3 R10 bus released in tx"}, 32'(bad_oe), 0);
            check(bad_tx == 0, {tag, " R10 tx word passthrough"}, first_act, first_exp);
        end
        @(negedge clk);
        #1;
        check(!bus_oe && !txf_valid && ack == 4'b0, {tag, " R4 block ends after BLOCK_WORDS"},
              {29'b0, bus_oe, txf_valid, |ack}, 0);
    endtask

    task automatic t_reset();
        int bad = 0;
        rx_enable = 1'b1; tx_enable = 1'b1; req_n = 4'h0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (ack != 4'b0 || bus_oe || underrun) bad++;
        end
        check(bad == 0, "R1 quiet during reset", 32'(bad), 0);
        @(negedge clk);
        req_n = 4'hF; sys_rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(ack == 4'b0 && !underrun, "R1 idle after reset", {28'b0, ack}, 0);
    endtask

    task automatic t_rx_single();
        int bad = 0;
        req_n = 4'b1110;
        do_block(0, 1'b1, 1'b0, "rx_single");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (ack != 4'b0) bad++;
        end
        check(bad == 0, "R7 released request not regranted", 32'(bad), 0);
        check(!underrun, "R11 no underrun with full fifo", {31'b0, underrun}, 0);
    endtask

    task automatic t_tx_single();
        req_n = 4'b0111;
        do_block(3, 1'b1, 1'b0, "tx_single");
    endtask

    task automatic t_enable_gate();
        int bad = 0;
        rx_enable = 1'b0; tx_enable = 1'b0;
        @(negedge clk);
        req_n = 4'b0000;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (ack != 4'b0) bad++;
        end
        check(bad == 0, "R5 R6 both enables low hold off", 32'(bad), 0);
        tx_enable = 1'b1;
        // only transmit eligible; ch3 served last -> ch2
        do_block(2, 1'b1, 1'b0, "R6 tx enabled");
        check(1'b1, "R5 rx still held off (ack checked tx)", 0, 0);
        rx_enable = 1'b1;
    endtask

    task automatic t_dir_rr();
        // last served direction is transmit -> receive first, then alternate
        req_n = 4'b0110;
        do_block(0, 1'b0, 1'b0, "R8 dir 1");
        do_block(3, 1'b0, 1'b0, "R8 dir 2");
        do_block(0, 1'b0, 1'b0, "R8 dir 3");
        do_block(3, 1'b1, 1'b0, "R8 dir 4");
    endtask

    task automatic t_chan_rr();
        // receive pair last served ch0 -> ch1 first
        req_n = 4'b1100;
        do_block(1, 1'b0, 1'b0, "R9 chan 1");
        do_block(0, 1'b0, 1'b0, "R9 chan 2");
        do_block(1, 1'b1, 1'b0, "R9 chan 3");
    endtask

    task automatic t_underrun();
        int bad = 0;
        req_n = 4'b1110;
        do_block(0, 1'b1, 1'b1, "R11 starve");
        check(underrun, "R11 underrun raised", {31'b0, underrun}, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (!underrun) bad++;
        end
        check(bad == 0, "R11 underrun sticky", 32'(bad), 0);
        @(negedge clk); sys_rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!underrun, "R1 reset clears underrun", {31'b0, underrun}, 0);
        sys_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_history();
        // both directions and both tx channels pending: rx ch0 first after reset
        req_n = 4'b0010;
        do_block(0, 1'b0, 1'b0, "R1 R8 history after reset");
        req_n = 4'b0011;
        do_block(2, 1'b1, 1'b0, "R1 R9 tx history after reset");
    endtask

    initial begin
        t_reset();
        t_rx_single();
        t_tx_single();
        t_enable_gate();
        t_dir_rr();
        t_chan_rr();
        t_underrun();
        t_reset_history();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule